// File: doc/BRIEF.md
# Serial Flash Status-Register Write Guard

This block is the slave-side command decoder that protects the status register of a serial flash device. It oversamples the serial clock, chip select, serial data input and the hardware write-protect pin with the system clock. It assembles each chip-select frame into an opcode byte and a payload byte. Only a two-step sequence changes the register: an arming instruction, then a status write in the very next frame. Any other complete or aborted frame between the two cancels the arm.

The status value is driven in parallel on `status`, so the rest of the device can use the protection bits directly. Four bits select the protected region and one lock bit works with the write-protect pin. While that pin is low, the lock bit can only be set and never cleared, and once it is set the register is frozen. The serial output stays floating for the whole time, because none of the decoded instructions return data.

Top module: `sfg_status_guard`

## Requirements
- R1: A synchronous active-low reset loads `status` with 8'h3C. The region-select bits 5:2 are 1 and bits 7, 6, 1 and 0 are 0. The arm is cleared.
- R2: A valid write updates `status`. Such a write is a frame with opcode 8'h01 and at least one data byte, both MSB first, in the frame right after an arming frame with opcode 8'h06 or 8'h50. Bits 7 and 5:2 take the data byte and bits 6, 1 and 0 always read 0.
- R3: A write frame has no effect on `status` when no arming frame came before it, or when any other complete frame lies between the arm and the write.
- R4: The arm is consumed by every complete write frame, whether or not the write is accepted. A second write without a new arm leaves `status` unchanged.
- R5: `status` changes only when chip select goes high. A frame whose bit count is zero or not a multiple of 8 is discarded and clears the arm. A write frame with fewer than 16 bits is also discarded and clears the arm.
- R6: If the write-protect pin is low and `status` bit 7 (lock) is 1 when the write frame ends, the write is ignored.
- R7: If the write-protect pin is low and the lock bit is 0, the write is accepted. It may set the lock bit and change the region bits in the same write.
- R8: If the write-protect pin is high, every writable bit may be changed, including clearing the lock bit.
- R9: Data is sampled on rising serial clock edges. Frames in clock-idle-low mode (mode 0) and clock-idle-high mode (mode 3) behave the same.
- R10: `so` is high impedance at all times.
- R11: A new `status` value appears after the fourth rising `clk` edge that follows chip select going high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; one frame per low period |
| si | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Active-low hardware write protect |
| so | output | 1 | Serial data out, always floating |
| status | output | 8 | Current status register value |

## Verification
The assertions assume the following about the inputs:
- Each serial clock phase lasts at least three `clk` periods.
- `si` is stable across every rising serial clock edge.
- Chip-select edges are separated from serial clock edges.
- `wp_n` is held steady around the end of a write frame.

Under these conditions, the synchronizer delivers one clean edge pulse per pin transition. The stimulus holds every serial clock phase for four system clocks and changes `si` only on falling edges. It waits several clocks between chip-select edges and the adjacent clock edges, and sets `wp_n` well before a frame starts.

// File: rtl/sfg_pkg.sv
// Shared constants and types for the status-register write guard.
// Assumes an 8-bit status register with a single lock bit at position 7.
package sfg_pkg;

    localparam int SR_W      = 8;
    localparam int LOCK_BIT  = 7;
    localparam int REGION_LO = 2;
    localparam int REGION_HI = 5;

    localparam logic [7:0] OP_ARM_WS = 8'h50;
    localparam logic [7:0] OP_ARM_WE = 8'h06;
    localparam logic [7:0] OP_WR_SR  = 8'h01;

    // Pin vector positions for the synchronizer.
    localparam int PIN_SI  = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_CS  = 2;
    localparam int PIN_WP  = 3;
    localparam int PIN_W   = 4;

    typedef enum logic [1:0] {
        CMD_DROP  = 2'd0,
        CMD_ARM   = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_OTHER = 2'd3
    } frame_cmd_e;

    // Mask of register bits that a write may change.
    function automatic logic [SR_W-1:0] region_mask();
        logic [SR_W-1:0] m;
        m = '0;
        for (int i = REGION_LO; i <= REGION_HI; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [SR_W-1:0] writable_mask();
        logic [SR_W-1:0] m;
        m = region_mask();
        m[LOCK_BIT] = 1'b1;
        return m;
    endfunction

    // Classify a finished frame from its bit count and first byte.
    function automatic frame_cmd_e classify(input logic [7:0] op, input int unsigned nbits);
        if (nbits == 0 || (nbits % 8) != 0) return CMD_DROP;
        if (op == OP_ARM_WS || op == OP_ARM_WE) return CMD_ARM;
        if (op == OP_WR_SR) return (nbits >= 16) ? CMD_WRITE : CMD_DROP;
        return CMD_OTHER;
    endfunction

endpackage

// File: rtl/sfg_pin_sync.sv
// Multi-stage synchronizer with edge detection for a vector of slow pins.
// Assumes each pin level lasts at least STAGES+1 clk periods so that every
// transition yields exactly one rise or fall pulse.
module sfg_pin_sync #(
    parameter int                 W       = 4,
    parameter int                 STAGES  = 2,
    parameter logic [W-1:0]       IDLE    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] chain_q [STAGES];
    logic [W-1:0] prev_q;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= IDLE;
        else        chain_q[0] <= pins_i;
    end

    // Remaining stages pass the value along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= IDLE;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    // One-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= IDLE;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;
    assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/sfg_frame_shift.sv
// Collects serial bits of one chip-select frame, MSB first.
// Holds the first byte as opcode and the second byte as payload.
// Emits a one-cycle end pulse with the bit count when the frame closes.
// The bit counter saturates at its maximum. A saturated count is not a
// multiple of 8, so such a frame is later discarded.
module sfg_frame_shift #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_i,
    input  logic             sel_start_i,
    input  logic             sel_end_i,
    input  logic             sck_rise_i,
    input  logic             bit_i,
    output logic             frame_end_o,
    output logic [CNT_W-1:0] frame_bits_o,
    output logic [7:0]       opcode_o,
    output logic [7:0]       payload_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [6:0]       shreg_q;
    logic [7:0]       op_q;
    logic [7:0]       dat_q;
    logic             end_q;
    logic [CNT_W-1:0] bits_q;
    logic             byte_done;
    logic [CNT_W-4:0] byte_idx;

    assign byte_done = sck_rise_i && sel_i && (cnt_q[2:0] == 3'd7) && (cnt_q != CNT_MAX);
    assign byte_idx  = cnt_q[CNT_W-1:3];

    // Bit counter and shift register for the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (sel_start_i) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (sck_rise_i && sel_i) begin
            shreg_q <= {shreg_q[5:0], bit_i};
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
    end

    // Byte capture into opcode and payload slots.
    always_ff @(posedge clk) begin
        if (!rst_n || sel_start_i) begin
            op_q  <= '0;
            dat_q <= '0;
        end else if (byte_done) begin
            if (byte_idx == '0)             op_q  <= {shreg_q, bit_i};
            else if (byte_idx == 'd1)       dat_q <= {shreg_q, bit_i};
        end
    end

    // Frame close pulse with the final bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q  <= 1'b0;
            bits_q <= '0;
        end else begin
            end_q <= sel_end_i;
            if (sel_end_i) bits_q <= cnt_q;
        end
    end

    assign frame_end_o  = end_q;
    assign frame_bits_o = bits_q;
    assign opcode_o     = op_q;
    assign payload_o    = dat_q;

    // R5: a new frame always starts counting from zero.
    p_count_cleared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_start_i |=> (cnt_q == '0));
endmodule

// File: rtl/sfg_sr_guard.sv
// Holds the status register and the arm flag. Applies the two-step write
// sequence and the lock/write-protect rules when a frame closes.
// Assumes wp_i is the synchronized pin level at the frame end pulse.
module sfg_sr_guard
    import sfg_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_end_i,
    input  logic [CNT_W-1:0] frame_bits_i,
    input  logic [7:0]       opcode_i,
    input  logic [7:0]       payload_i,
    input  logic             wp_i,
    output logic [SR_W-1:0]  status_o
);
    localparam logic [SR_W-1:0] WR_MASK = writable_mask();
    localparam logic [SR_W-1:0] RST_SR  = region_mask();

    logic [SR_W-1:0] sr_q;
    logic            armed_q;
    frame_cmd_e      cmd;
    logic            locked;

    assign cmd    = classify(opcode_i, int'(frame_bits_i));
    assign locked = !wp_i && sr_q[LOCK_BIT];

    // Arm flag: set by an arming frame, cleared by any other frame end.
    always_ff @(posedge clk) begin
        if (!rst_n)           armed_q <= 1'b0;
        else if (frame_end_i) armed_q <= (cmd == CMD_ARM);
    end

    // Status register: loads masked payload on an allowed write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= RST_SR;
        else if (frame_end_i && cmd == CMD_WRITE && armed_q && !locked)
            sr_q <= payload_i & WR_MASK;
    end

    assign status_o = sr_q;

    // R5: the register moves only on a frame end.
    p_hold_between_frames_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_end_i |=> $stable(sr_q));
    // R4: any complete write consumes the arm.
    p_arm_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && cmd == CMD_WRITE) |=> !armed_q);
    // R6: locked with protect pin low freezes the register.
    p_locked_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && !wp_i && sr_q[LOCK_BIT]) |=> $stable(sr_q));
    // R7: with protect pin low the lock bit never falls.
    p_lock_one_way_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end_i && !wp_i) |=> !$fell(sr_q[LOCK_BIT]));
endmodule

// File: rtl/sfg_status_guard.sv
// Top level: synchronizes the serial pins, frames the bits, guards the
// status register. Assumes clk runs well above the serial clock.
module sfg_status_guard
    import sfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sck,
    input  logic            cs_n,
    input  logic            si,
    input  logic            wp_n,
    output logic            so,
    output logic [SR_W-1:0] status
);
    localparam logic [PIN_W-1:0] PIN_IDLE = (1 << PIN_CS) | (1 << PIN_WP);

    logic [PIN_W-1:0] pin_raw, pin_lvl, pin_rise, pin_fall;
    logic             frame_end;
    logic [CNT_W-1:0] frame_bits;
    logic [7:0]       opcode, payload;

    // Pack pins into one vector for the synchronizer.
    always_comb begin
        pin_raw          = '0;
        pin_raw[PIN_SI]  = si;
        pin_raw[PIN_SCK] = sck;
        pin_raw[PIN_CS]  = cs_n;
        pin_raw[PIN_WP]  = wp_n;
    end

    sfg_pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .IDLE(PIN_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pin_raw),
        .level_o (pin_lvl),
        .rise_o  (pin_rise),
        .fall_o  (pin_fall)
    );

    sfg_frame_shift #(.CNT_W(CNT_W)) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel_i        (!pin_lvl[PIN_CS]),
        .sel_start_i  (pin_fall[PIN_CS]),
        .sel_end_i    (pin_rise[PIN_CS]),
        .sck_rise_i   (pin_rise[PIN_SCK]),
        .bit_i        (pin_lvl[PIN_SI]),
        .frame_end_o  (frame_end),
        .frame_bits_o (frame_bits),
        .opcode_o     (opcode),
        .payload_o    (payload)
    );

    sfg_sr_guard #(.CNT_W(CNT_W)) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_end_i  (frame_end),
        .frame_bits_i (frame_bits),
        .opcode_i     (opcode),
        .payload_i    (payload),
        .wp_i         (pin_lvl[PIN_WP]),
        .status_o     (status)
    );

    // Serial output is never driven by these instructions.
    assign so = 1'bz;
endmodule

// File: tb/sfg_status_guard_test.sv
module sfg_status_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       si = 1'b0;
    logic       wp_n = 1'b1;
    wire        so;
    logic [7:0] status;

    int         vectors = 0;
    int         miscompares = 0;
    int         cycles = 0;
    string      cur_req = "R1";

    // Behavioural reference state.
    logic [7:0] exp_now = 8'h3C;
    bit         m_armed = 1'b0;
    logic [7:0] exp_q[$];

    always #2.5 clk = ~clk;

    sfg_status_guard uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
        .si(si), .wp_n(wp_n), .so(so), .status(status)
    );

    // R11 latency: the expected value trails the model by four clk edges.
    always @(posedge clk) begin
        exp_q.push_back(exp_now);
        if (exp_q.size() > 4) exp_q.pop_front();
    end

    // Per-cycle comparison of outputs against the delayed model.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && exp_q.size() == 4) begin
            vectors++;
            if (status !== exp_q[0]) begin
                miscompares++;
                $display("FAIL %s/R11 status act=%h exp=%h t=%0t", cur_req, status, exp_q[0], $time);
            end
            vectors++;
            if (so !== 1'bz) begin
                miscompares++;
                $display("FAIL R10 so act=%b exp=z t=%0t", so, $time);
            end
        end
        if (cycles > 100000) begin
            miscompares++;
            $display("FAIL watchdog act=%0d exp<=100000 cycles", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Model update at the end of a frame.
    task automatic model_end(input logic [15:0] word, input int n);
        logic [7:0] op;
        op = word[15:8];
        if (n == 0 || (n % 8) != 0) begin
            m_armed = 1'b0;
        end else if (op == 8'h06 || op == 8'h50) begin
            m_armed = 1'b1;
        end else begin
            if (op == 8'h01 && n >= 16 && m_armed && !(wp_n == 1'b0 && exp_now[7]))
                exp_now = word[7:0] & 8'hBC;
            m_armed = 1'b0;
        end
    endtask

    // One chip-select frame of n bits taken from the top of word, MSB first.
    task automatic frame(input logic [15:0] word, input int n, input bit mode3);
        sck = mode3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(4);
        for (int i = 0; i < n; i++) begin
            sck = 1'b0;
            si  = word[15-i];
            wait_clk(4);
            sck = 1'b1;
            wait_clk(4);
        end
        sck = mode3;
        wait_clk(4);
        cs_n = 1'b1;
        model_end(word, n);
        wait_clk(8);
    endtask

    task automatic arm(input logic [7:0] op, input bit mode3);
        frame({op, 8'h00}, 8, mode3);
    endtask

    task automatic wr(input logic [7:0] d, input bit mode3);
        frame({8'h01, d}, 16, mode3);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(8);

        // R1: reset value is held with no traffic
        cur_req = "R1";
        wait_clk(10);

        // R2: both arming opcodes enable one write
        cur_req = "R2";
        arm(8'h06, 0); wr(8'h00, 0);
        arm(8'h50, 0); wr(8'hFF, 0);

        // R8: protect pin high allows clearing the lock bit
        cur_req = "R8";
        wp_n = 1'b1;
        arm(8'h06, 0); wr(8'h14, 0);

        // R3: write without arm, and with another frame in between
        cur_req = "R3";
        wr(8'h3C, 0);
        arm(8'h50, 0); frame({8'h05, 8'h00}, 8, 0); wr(8'h3C, 0);

        // R4: second write after an accepted one is ignored
        cur_req = "R4";
        arm(8'h06, 0); wr(8'h08, 0); wr(8'h30, 0);

        // R5: partial frames are discarded and clear the arm
        cur_req = "R5";
        arm(8'h06, 0); frame(16'h01F0, 12, 0); wr(8'h20, 0);
        arm(8'h06, 0); frame({8'h01, 8'h00}, 8, 0); wr(8'h20, 0);
        frame({8'h06, 8'h00}, 7, 0); wr(8'h20, 0);
        arm(8'h06, 0); frame(16'h0000, 0, 0); wr(8'h20, 0);

        // R7: protect pin low, lock clear: lock and region set together
        cur_req = "R7";
        wp_n = 1'b0;
        wait_clk(8);
        arm(8'h06, 0); wr(8'hA4, 0);

        // R6: protect pin low, lock set: write ignored
        cur_req = "R6";
        arm(8'h50, 0); wr(8'h00, 0);
        arm(8'h06, 0); wr(8'hBC, 0);

        // R8: releasing the protect pin unlocks
        cur_req = "R8";
        wp_n = 1'b1;
        wait_clk(8);
        arm(8'h06, 0); wr(8'h00, 0);

        // R9: clock-idle-high frames
        cur_req = "R9";
        arm(8'h50, 1); wr(8'h28, 1);
        wr(8'h10, 1);
        arm(8'h06, 1); wr(8'h94, 1);

        wait_clk(12);
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule